// File: doc/BRIEF.md
# Page-granular memory access firewall

This block guards a small on-chip RAM split into 32 pages of 4 KiB. Each page is divided into eight 512-byte sub-blocks. Every bus access carries an address, a 3-bit compartment ID, a secure flag, a privileged flag and a direction. The block decides in the same cycle whether the access may reach the memory. It gates the memory request and write enable, and it returns a registered grant/deny response one cycle later. A blocked read returns zero on the data path. A blocked write never reaches the memory.

Rights come from several sources. Each page has per-sub-block secure and default-privilege masks. Each page can also turn on a compartment filter. When the filter is on, per-compartment read, write and privilege bitmaps hold one bit per page. A control bit lets secure masters reach non-secure sub-blocks. The first blocked access after a clear latches the faulting address and a syndrome and raises a sticky flag. A second sticky flag records rejected writes to a page's filter configuration. Only the owning compartment may write that configuration: the trusted compartment, or the delegated compartment when delegation is on.

Top module: `page_firewall`

## Requirements
- R1: After reset, every register reads 0 and both flags are clear. A non-secure, unprivileged read or write from any compartment to any page is granted.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `acc_valid` high. `rsp_grant` equals the decision made for that access. `mem_req` is high in the request cycle only when the access is allowed.
- R3: The page secure mask is at 0x100+4*page, with bit n covering sub-block n = address[11:9]. A non-secure access to a sub-block whose bit is set is blocked. A secure access to such a sub-block passes this check.
- R4: A secure access to a non-secure sub-block is blocked unless control register 0x000 bit 31 is set.
- R5: The page default-privilege mask is at 0x200+4*page, bit n for sub-block n. With filtering off, an unprivileged access to a sub-block whose bit is set is blocked, and a privileged one is not.
- R6: Page filter configuration is at 0xA00+4*page: bit 0 enables filtering, bit 2 enables delegation, bits [6:4] hold the delegate ID. With filtering on, a read needs bit `page` of the compartment's read bitmap (0x808+0x20*cid). A write needs the write bitmap bit (0x810+0x20*cid). If the privilege bitmap bit (0x800+0x20*cid) is set, the access must also be privileged. The default-privilege mask is ignored. Compartment ID 7 is always blocked.
- R7: A denied response returns 0 on `acc_rdata`. A granted one returns `mem_rdata`. `mem_we` is high only for an allowed write.
- R8: On a blocked access while the illegal-access flag is clear, the block sets the flag and latches the following. Status 0x008 bit 1 reads 1. 0x024 holds the zero-extended address. 0x020 holds the syndrome: [2:0] ID, [4] secure, [5] privileged, [6] write. Later violations leave the capture unchanged. `viol_alert` mirrors the flag.
- R9: Writing 1 to bit 1 of 0x00C clears the illegal-access flag, and writing 1 to bit 0 clears the configuration flag (status bit 0). A violation in the same cycle as a clear wins: the flag stays set and the new access is captured.
- R10: A write to a page filter configuration is accepted only from ID 1 when that page's delegation bit is clear, or only from the delegate ID when it is set. A rejected write leaves the register unchanged and sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 12 | Configuration byte address (word aligned) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_cid | input | 3 | Compartment ID of the configuring master |
| cfg_rdata | output | 32 | Configuration read data (same cycle) |
| acc_valid | input | 1 | Memory access request |
| acc_addr | input | 17 | Byte offset into the protected memory |
| acc_cid | input | 3 | Requester compartment ID |
| acc_sec | input | 1 | Requester is secure |
| acc_priv | input | 1 | Requester is privileged |
| acc_write | input | 1 | 1 = write |
| mem_req | output | 1 | Allowed access forwarded to memory |
| mem_we | output | 1 | Allowed write enable to memory |
| mem_rdata | input | 32 | Read data from memory, response cycle |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_grant | output | 1 | 1 = access was granted |
| acc_rdata | output | 32 | Read data returned to the requester |
| viol_alert | output | 1 | Illegal-access flag |

## Verification
Directed cases toggle each rights source on its own against the reset state. A single sub-block bit in the secure or privilege mask is set, and its neighbour sub-block is checked to separate sub-block decoding from page decoding. Filtered pages are probed with reads against writes and with privileged against unprivileged requesters. ID 7 is tried as well, which separates bitmap selection from the default-privilege path. Ownership is tested by writes from the trusted, wrong and delegate IDs. A clear is issued in the same cycle as a violation. Random configuration writes mixed with random accesses then compare every grant, and the final capture registers, against a reference model of the rules.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
    localparam int CID_W    = 3;
    localparam int CFG_AW   = 12;
    localparam int DATA_W   = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int SRWNS_BIT  = 31;

    // register block selectors, cfg_addr[11:8]
    localparam logic [3:0] BLK_GLOBAL = 4'h0;
    localparam logic [3:0] BLK_SECM   = 4'h1;
    localparam logic [3:0] BLK_PRVM   = 4'h2;
    localparam logic [3:0] BLK_CMPT   = 4'h8;
    localparam logic [3:0] BLK_FILT   = 4'hA;

    // offsets inside the global block
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h08;
    localparam logic [7:0] OFS_CLR   = 8'h0C;
    localparam logic [7:0] OFS_SYND  = 8'h20;
    localparam logic [7:0] OFS_VADDR = 8'h24;

    // offsets inside one compartment slot
    localparam logic [4:0] CMPT_PRV = 5'h00;
    localparam logic [4:0] CMPT_RD  = 5'h08;
    localparam logic [4:0] CMPT_WR  = 5'h10;

    typedef struct packed {
        logic [CID_W-1:0] dcid;
        logic             rsvd3;
        logic             dcen;
        logic             rsvd1;
        logic             cfen;
    } pfilt_t;

    typedef struct packed {
        logic             wr;
        logic             priv;
        logic             sec;
        logic             rsvd;
        logic [CID_W-1:0] cid;
    } synd_t;
endpackage

// File: rtl/pfw_regs.sv
module pfw_regs
    import pfw_pkg::*;
#(
    parameter int NUM_PAGES   = 32,
    parameter int NUM_CID     = 7,
    parameter int SUBS        = 8,
    parameter int TRUSTED_CID = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_valid,
    input  logic                             cfg_write,
    input  logic [CFG_AW-1:0]                cfg_addr,
    input  logic [DATA_W-1:0]                cfg_wdata,
    input  logic [CID_W-1:0]                 cfg_cid,
    output logic [DATA_W-1:0]                cfg_rdata,
    input  logic                             ill_i,
    input  logic                             cfgf_i,
    input  logic [DATA_W-1:0]                vaddr_i,
    input  synd_t                            synd_i,
    output logic                             clr_cfg_o,
    output logic                             clr_ill_o,
    output logic                             reject_o,
    output logic                             srwns_o,
    output logic [NUM_PAGES-1:0][SUBS-1:0]   sec_o,
    output logic [NUM_PAGES-1:0][SUBS-1:0]   prv_o,
    output logic [NUM_PAGES-1:0]             filt_en_o,
    output logic [NUM_CID-1:0][NUM_PAGES-1:0] rdm_o,
    output logic [NUM_CID-1:0][NUM_PAGES-1:0] wrm_o,
    output logic [NUM_CID-1:0][NUM_PAGES-1:0] pvm_o
);
    localparam int PAGE_W = $clog2(NUM_PAGES);

    typedef struct packed {
        logic                              srwns;
        logic [NUM_PAGES-1:0][SUBS-1:0]    sec;
        logic [NUM_PAGES-1:0][SUBS-1:0]    prv;
        pfilt_t [NUM_PAGES-1:0]            filt;
        logic [NUM_CID-1:0][NUM_PAGES-1:0] rdm;
        logic [NUM_CID-1:0][NUM_PAGES-1:0] wrm;
        logic [NUM_CID-1:0][NUM_PAGES-1:0] pvm;
    } rf_t;

    rf_t rf_d, rf_q;

    logic [5:0]        pidx;
    logic [2:0]        cidx;
    logic [PAGE_W-1:0] pi;
    logic              pok, cok, wr_en, rd_en;
    logic [CID_W-1:0]  owner;

    always_comb begin
        rf_d      = rf_q;
        cfg_rdata = '0;
        clr_cfg_o = 1'b0;
        clr_ill_o = 1'b0;
        reject_o  = 1'b0;
        pidx  = cfg_addr[7:2];
        cidx  = cfg_addr[7:5];
        pi    = pidx[PAGE_W-1:0];
        pok   = int'(pidx) < NUM_PAGES;
        cok   = int'(cidx) < NUM_CID;
        wr_en = cfg_valid && cfg_write && (cfg_addr[1:0] == 2'b00);
        rd_en = cfg_valid && !cfg_write && (cfg_addr[1:0] == 2'b00);
        owner = rf_q.filt[pi].dcen ? rf_q.filt[pi].dcid : CID_W'(TRUSTED_CID);
        case (cfg_addr[11:8])
            BLK_GLOBAL: begin
                case (cfg_addr[7:0])
                    OFS_CTRL: begin
                        if (rd_en) cfg_rdata[SRWNS_BIT] = rf_q.srwns;
                        if (wr_en) rf_d.srwns = cfg_wdata[SRWNS_BIT];
                    end
                    OFS_STAT: if (rd_en) cfg_rdata[1:0] = {ill_i, cfgf_i};
                    OFS_CLR: if (wr_en) begin
                        clr_cfg_o = cfg_wdata[0];
                        clr_ill_o = cfg_wdata[1];
                    end
                    OFS_SYND:  if (rd_en) cfg_rdata[$bits(synd_t)-1:0] = synd_i;
                    OFS_VADDR: if (rd_en) cfg_rdata = vaddr_i;
                    default: ;
                endcase
            end
            BLK_SECM: if (pok) begin
                if (rd_en) cfg_rdata[SUBS-1:0] = rf_q.sec[pi];
                if (wr_en) rf_d.sec[pi] = cfg_wdata[SUBS-1:0];
            end
            BLK_PRVM: if (pok) begin
                if (rd_en) cfg_rdata[SUBS-1:0] = rf_q.prv[pi];
                if (wr_en) rf_d.prv[pi] = cfg_wdata[SUBS-1:0];
            end
            BLK_CMPT: if (cok) begin
                case (cfg_addr[4:0])
                    CMPT_PRV: begin
                        if (rd_en) cfg_rdata[NUM_PAGES-1:0] = rf_q.pvm[cidx];
                        if (wr_en) rf_d.pvm[cidx] = cfg_wdata[NUM_PAGES-1:0];
                    end
                    CMPT_RD: begin
                        if (rd_en) cfg_rdata[NUM_PAGES-1:0] = rf_q.rdm[cidx];
                        if (wr_en) rf_d.rdm[cidx] = cfg_wdata[NUM_PAGES-1:0];
                    end
                    CMPT_WR: begin
                        if (rd_en) cfg_rdata[NUM_PAGES-1:0] = rf_q.wrm[cidx];
                        if (wr_en) rf_d.wrm[cidx] = cfg_wdata[NUM_PAGES-1:0];
                    end
                    default: ;
                endcase
            end
            BLK_FILT: if (pok) begin
                if (rd_en) cfg_rdata[$bits(pfilt_t)-1:0] = rf_q.filt[pi];
                if (wr_en) begin
                    if (cfg_cid == owner) begin
                        rf_d.filt[pi] = '{dcid: cfg_wdata[6:4], rsvd3: 1'b0,
                                          dcen: cfg_wdata[2], rsvd1: 1'b0,
                                          cfen: cfg_wdata[0]};
                    end else begin
                        reject_o = 1'b1; // R10: foreign owner
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign srwns_o = rf_q.srwns;
    assign sec_o   = rf_q.sec;
    assign prv_o   = rf_q.prv;
    assign rdm_o   = rf_q.rdm;
    assign wrm_o   = rf_q.wrm;
    assign pvm_o   = rf_q.pvm;

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_filt
        assign filt_en_o[g] = rf_q.filt[g].cfen;
    end

    // a rejected ownership write must leave every filter register untouched
    assert_reject_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |=> $stable(rf_q.filt));
endmodule

// File: rtl/pfw_decide.sv
module pfw_decide
    import pfw_pkg::*;
#(
    parameter int NUM_PAGES = 32,
    parameter int NUM_CID   = 7,
    parameter int SUBS      = 8,
    localparam int PAGE_W   = $clog2(NUM_PAGES),
    localparam int SUB_W    = $clog2(SUBS)
) (
    input  logic [PAGE_W+SUB_W-1:0]           blk_idx,
    input  logic [CID_W-1:0]                  acc_cid,
    input  logic                              acc_sec,
    input  logic                              acc_priv,
    input  logic                              acc_write,
    input  logic                              srwns_i,
    input  logic [NUM_PAGES-1:0][SUBS-1:0]    sec_i,
    input  logic [NUM_PAGES-1:0][SUBS-1:0]    prv_i,
    input  logic [NUM_PAGES-1:0]              filt_en_i,
    input  logic [NUM_CID-1:0][NUM_PAGES-1:0] rdm_i,
    input  logic [NUM_CID-1:0][NUM_PAGES-1:0] wrm_i,
    input  logic [NUM_CID-1:0][NUM_PAGES-1:0] pvm_i,
    output logic                              allow_o
);
    logic [PAGE_W-1:0] page;
    logic [SUB_W-1:0]  sub;
    logic sb, pb, known, rb, wb, pvb, sec_ok, rights_ok;

    always_comb begin
        page = blk_idx[PAGE_W+SUB_W-1:SUB_W];
        sub  = blk_idx[SUB_W-1:0];
        sb   = sec_i[page][sub];
        pb   = prv_i[page][sub];
        known = 1'b0;
        rb = 1'b0;
        wb = 1'b0;
        pvb = 1'b0;
        for (int c = 0; c < NUM_CID; c++) begin
            if (acc_cid == CID_W'(c)) begin
                known = 1'b1;
                rb  = rdm_i[c][page];
                wb  = wrm_i[c][page];
                pvb = pvm_i[c][page];
            end
        end
        sec_ok = acc_sec ? (sb || srwns_i) : !sb;
        if (filt_en_i[page])
            rights_ok = known && (acc_write ? wb : rb) && (!pvb || acc_priv);
        else
            rights_ok = !pb || acc_priv;
        allow_o = sec_ok && rights_ok;
    end
endmodule

// File: rtl/pfw_viol.sv
module pfw_viol
    import pfw_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              allow_i,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CID_W-1:0]  acc_cid,
    input  logic              acc_sec,
    input  logic              acc_priv,
    input  logic              acc_write,
    input  logic              clr_cfg_i,
    input  logic              clr_ill_i,
    input  logic              reject_i,
    output logic              ill_o,
    output logic              cfgf_o,
    output logic [DATA_W-1:0] vaddr_o,
    output synd_t             synd_o
);
    typedef struct packed {
        logic              ill;
        logic              cfgf;
        logic [DATA_W-1:0] vaddr;
        synd_t             synd;
    } vs_t;

    vs_t vs_d, vs_q;
    logic deny;

    always_comb begin
        vs_d = vs_q;
        deny = acc_valid && !allow_i;
        if (clr_cfg_i) vs_d.cfgf = 1'b0;
        if (reject_i)  vs_d.cfgf = 1'b1;
        if (clr_ill_i) vs_d.ill  = 1'b0;
        if (deny) begin
            vs_d.ill = 1'b1;
            if (!vs_q.ill || clr_ill_i) begin
                vs_d.vaddr = '0;
                vs_d.vaddr[ADDR_W-1:0] = acc_addr;
                vs_d.synd = '{wr: acc_write, priv: acc_priv, sec: acc_sec,
                              rsvd: 1'b0, cid: acc_cid};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vs_q <= '0;
        else        vs_q <= vs_d;
    end

    assign ill_o   = vs_q.ill;
    assign cfgf_o  = vs_q.cfgf;
    assign vaddr_o = vs_q.vaddr;
    assign synd_o  = vs_q.synd;

    assert_flag_on_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !allow_i) |=> ill_o);
    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ill_o && !clr_ill_i) |=> ($stable(vaddr_o) && $stable(synd_o)));
    assert_clear_ill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ill_i && !(acc_valid && !allow_i)) |=> !ill_o);
    assert_reject_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reject_i |=> cfgf_o);
endmodule

// File: rtl/page_firewall.sv
module page_firewall
    import pfw_pkg::*;
#(
    parameter int NUM_PAGES   = 32,
    parameter int NUM_CID     = 7,
    parameter int SUBS        = 8,
    parameter int TRUSTED_CID = 1,
    localparam int PAGE_W     = $clog2(NUM_PAGES),
    localparam int SUB_W      = $clog2(SUBS),
    localparam int ADDR_W     = PAGE_W + PAGE_SHIFT,
    localparam int SUB_SHIFT  = PAGE_SHIFT - SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [CID_W-1:0]  cfg_cid,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CID_W-1:0]  acc_cid,
    input  logic              acc_sec,
    input  logic              acc_priv,
    input  logic              acc_write,
    output logic              mem_req,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              viol_alert
);
    logic                              srwns_w, allow_w;
    logic [NUM_PAGES-1:0][SUBS-1:0]    sec_w, prv_w;
    logic [NUM_PAGES-1:0]              filt_en_w;
    logic [NUM_CID-1:0][NUM_PAGES-1:0] rdm_w, wrm_w, pvm_w;
    logic                              clr_cfg_w, clr_ill_w, reject_w;
    logic                              ill_w, cfgf_w;
    logic [DATA_W-1:0]                 vaddr_w;
    synd_t                             synd_w;

    pfw_regs #(
        .NUM_PAGES(NUM_PAGES), .NUM_CID(NUM_CID), .SUBS(SUBS), .TRUSTED_CID(TRUSTED_CID)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_cid(cfg_cid), .cfg_rdata(cfg_rdata),
        .ill_i(ill_w), .cfgf_i(cfgf_w), .vaddr_i(vaddr_w), .synd_i(synd_w),
        .clr_cfg_o(clr_cfg_w), .clr_ill_o(clr_ill_w), .reject_o(reject_w),
        .srwns_o(srwns_w), .sec_o(sec_w), .prv_o(prv_w), .filt_en_o(filt_en_w),
        .rdm_o(rdm_w), .wrm_o(wrm_w), .pvm_o(pvm_w)
    );

    pfw_decide #(
        .NUM_PAGES(NUM_PAGES), .NUM_CID(NUM_CID), .SUBS(SUBS)
    ) u_decide (
        .blk_idx(acc_addr[ADDR_W-1:SUB_SHIFT]), .acc_cid(acc_cid), .acc_sec(acc_sec),
        .acc_priv(acc_priv), .acc_write(acc_write), .srwns_i(srwns_w),
        .sec_i(sec_w), .prv_i(prv_w), .filt_en_i(filt_en_w),
        .rdm_i(rdm_w), .wrm_i(wrm_w), .pvm_i(pvm_w), .allow_o(allow_w)
    );

    pfw_viol #(.ADDR_W(ADDR_W)) u_viol (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .allow_i(allow_w),
        .acc_addr(acc_addr), .acc_cid(acc_cid), .acc_sec(acc_sec),
        .acc_priv(acc_priv), .acc_write(acc_write),
        .clr_cfg_i(clr_cfg_w), .clr_ill_i(clr_ill_w), .reject_i(reject_w),
        .ill_o(ill_w), .cfgf_o(cfgf_w), .vaddr_o(vaddr_w), .synd_o(synd_w)
    );

    typedef struct packed {
        logic vld;
        logic grant;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        mem_req   = acc_valid && allow_w;
        mem_we    = mem_req && acc_write;
        rsp_d.vld   = acc_valid;
        rsp_d.grant = acc_valid && allow_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.vld;
    assign rsp_grant  = rsp_q.grant;
    assign acc_rdata  = (rsp_q.vld && rsp_q.grant) ? mem_rdata : '0;
    assign viol_alert = ill_w;

    logic [PAGE_W-1:0] a_page;
    logic [SUB_W-1:0]  a_sub;
    assign a_page = acc_addr[ADDR_W-1:PAGE_SHIFT];
    assign a_sub  = acc_addr[PAGE_SHIFT-1:SUB_SHIFT];

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);
    assert_grant_matches_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (rsp_grant == $past(mem_req)));
    assert_nonsec_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_sec && sec_w[a_page][a_sub]) |-> !mem_req);
    assert_sec_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_sec && !srwns_w && !sec_w[a_page][a_sub]) |-> !mem_req);
    assert_denied_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant) |-> (acc_rdata == '0));
endmodule

// File: tb/test_page_firewall.sv
module test_page_firewall;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 0, cfg_write = 0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  cfg_cid = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 0, acc_sec = 0, acc_priv = 0, acc_write = 0;
    logic [16:0] acc_addr = '0;
    logic [2:0]  acc_cid = '0;
    logic        mem_req, mem_we, rsp_valid, rsp_grant, viol_alert;
    logic [31:0] mem_rdata = '0;
    logic [31:0] acc_rdata;

    always #2 clk = ~clk;

    page_firewall i_page_firewall (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_cid(cfg_cid),
        .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_cid(acc_cid), .acc_sec(acc_sec), .acc_priv(acc_priv),
        .acc_write(acc_write), .mem_req(mem_req), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .acc_rdata(acc_rdata), .viol_alert(viol_alert)
    );

    int checks = 0;
    int fails  = 0;

    // reference state of the rules
    bit [7:0]  m_sec [32];
    bit [7:0]  m_prv [32];
    bit [6:0]  m_flt [32];
    bit [31:0] m_rd [7];
    bit [31:0] m_wr [7];
    bit [31:0] m_pv [7];
    bit        m_srw, m_ill, m_cfg;
    bit [31:0] m_va;
    bit [6:0]  m_sy;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit exp_allow(bit [16:0] a, bit [2:0] cid, bit s, bit p, bit w);
        bit [4:0] pg = a[16:12];
        bit [2:0] sb = a[11:9];
        bit sec_ok, r;
        sec_ok = s ? (m_sec[pg][sb] | m_srw) : !m_sec[pg][sb];
        if (!m_flt[pg][0]) r = !m_prv[pg][sb] || p;
        else if (cid == 3'd7) r = 1'b0;
        else r = (w ? m_wr[cid][pg] : m_rd[cid][pg]) && (!m_pv[cid][pg] || p);
        return sec_ok && r;
    endfunction

    task automatic model_cfg(input bit [11:0] a, input bit [31:0] d, input bit [2:0] cid);
        bit [4:0] pg = a[6:2];
        bit [2:0] owner;
        case (a[11:8])
            4'h0: begin
                if (a[7:0] == 8'h00) m_srw = d[31];
                if (a[7:0] == 8'h0C) begin
                    if (d[0]) m_cfg = 0;
                    if (d[1]) m_ill = 0;
                end
            end
            4'h1: m_sec[pg] = d[7:0];
            4'h2: m_prv[pg] = d[7:0];
            4'h8: if (a[7:5] < 3'd7) begin
                case (a[4:0])
                    5'h00: m_pv[a[7:5]] = d;
                    5'h08: m_rd[a[7:5]] = d;
                    5'h10: m_wr[a[7:5]] = d;
                    default: ;
                endcase
            end
            4'hA: begin
                owner = m_flt[pg][2] ? m_flt[pg][6:4] : 3'd1;
                if (cid == owner) m_flt[pg] = d[6:0] & 7'h75;
                else m_cfg = 1;
            end
            default: ;
        endcase
    endtask

    task automatic cfg_wr(input bit [11:0] a, input bit [31:0] d, input bit [2:0] cid);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 1; cfg_addr = a; cfg_wdata = d; cfg_cid = cid;
        model_cfg(a, d, cid);
        @(negedge clk);
        cfg_valid = 0; cfg_write = 0;
    endtask

    task automatic cfg_rd(input bit [11:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 0; cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_valid = 0;
    endtask

    task automatic rd_chk(input string req, input bit [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        cfg_rd(a, v);
        check(req, v, exp);
    endtask

    task automatic note_access(input bit [16:0] a, input bit [2:0] cid, input bit s,
                               input bit p, input bit w, input bit e, input bit clr);
        if (!e) begin
            if (!m_ill || clr) begin
                m_va = {15'h0, a};
                m_sy = {w, p, s, 1'b0, cid};
            end
            m_ill = 1;
        end
    endtask

    task automatic access(input bit [16:0] a, input bit [2:0] cid, input bit s,
                          input bit p, input bit w, input string req);
        bit e;
        logic [31:0] md;
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_cid = cid; acc_sec = s; acc_priv = p; acc_write = w;
        md = $urandom;
        mem_rdata = md;
        e = exp_allow(a, cid, s, p, w);
        #1;
        check(req, {31'b0, mem_req}, {31'b0, e});
        check("R7 mem_we", {31'b0, mem_we}, {31'b0, e && w});
        note_access(a, cid, s, p, w, e, 1'b0);
        @(negedge clk);
        acc_valid = 0;
        check("R2 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        check(req, {31'b0, rsp_grant}, {31'b0, e});
        check("R7 rdata", acc_rdata, e ? md : 32'h0);
        check("R8 alert", {31'b0, viol_alert}, {31'b0, m_ill});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd5417));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd_chk("R1 ctrl", 12'h000, 32'h0);
        rd_chk("R1 status", 12'h008, 32'h0);
        rd_chk("R1 filt", 12'hA04, 32'h0);
        check("R1 alert", {31'b0, viol_alert}, 32'h0);
        check("R2 idle", {31'b0, rsp_valid}, 32'h0);
        access(17'h00040, 3'd0, 0, 0, 0, "R1 read");
        access(17'h1F000, 3'd3, 0, 0, 1, "R1 write");

        // R4 secure master blocked on non-secure memory, R8 capture
        access(17'h02200, 3'd1, 1, 1, 0, "R4 deny");
        rd_chk("R8 status", 12'h008, 32'h2);
        rd_chk("R8 addr", 12'h024, 32'h0000_2200);
        rd_chk("R8 synd", 12'h020, 32'h31);
        access(17'h05000, 3'd2, 1, 0, 1, "R4 deny2");
        rd_chk("R8 addr held", 12'h024, 32'h0000_2200);
        rd_chk("R8 synd held", 12'h020, 32'h31);

        // R9 clear
        cfg_wr(12'h00C, 32'h2, 3'd0);
        rd_chk("R9 cleared", 12'h008, 32'h0);
        check("R9 alert", {31'b0, viol_alert}, 32'h0);

        // R4 window enable
        cfg_wr(12'h000, 32'h8000_0000, 3'd0);
        rd_chk("R4 ctrl", 12'h000, 32'h8000_0000);
        access(17'h05000, 3'd2, 1, 0, 1, "R4 allowed");

        // R3 secure sub-block
        cfg_wr(12'h10C, 32'h04, 3'd0);
        rd_chk("R3 mask", 12'h10C, 32'h04);
        access(17'h03400, 3'd0, 0, 0, 0, "R3 nonsec deny");
        access(17'h03600, 3'd0, 0, 0, 0, "R3 neighbour");
        access(17'h03400, 3'd0, 1, 0, 0, "R3 sec ok");

        // R5 default privilege
        cfg_wr(12'h214, 32'h01, 3'd0);
        access(17'h05010, 3'd0, 0, 0, 0, "R5 unpriv deny");
        access(17'h05010, 3'd0, 0, 1, 0, "R5 priv ok");
        access(17'h05200, 3'd0, 0, 0, 0, "R5 neighbour");

        // R10 ownership of filter config, page 7
        cfg_wr(12'hA1C, 32'h01, 3'd0);
        rd_chk("R10 rejected", 12'hA1C, 32'h0);
        rd_chk("R10 status", 12'h008, {30'b0, m_ill, m_cfg});
        cfg_wr(12'hA1C, 32'h01, 3'd1);
        rd_chk("R10 trusted", 12'hA1C, 32'h01);

        // R6 filtering
        access(17'h07000, 3'd2, 0, 0, 0, "R6 no bitmap");
        cfg_wr(12'h848, 32'h80, 3'd0);
        access(17'h07000, 3'd2, 0, 0, 0, "R6 read ok");
        access(17'h07000, 3'd2, 0, 0, 1, "R6 write deny");
        cfg_wr(12'h840, 32'h80, 3'd0);
        access(17'h07000, 3'd2, 0, 0, 0, "R6 priv needed");
        access(17'h07000, 3'd2, 0, 1, 0, "R6 priv ok");
        access(17'h07000, 3'd7, 0, 1, 0, "R6 id7");
        cfg_wr(12'h21C, 32'hFF, 3'd0);
        cfg_wr(12'h868, 32'h80, 3'd0);
        access(17'h07000, 3'd3, 0, 0, 0, "R6 default priv ignored");

        // R10 delegation
        cfg_wr(12'hA1C, 32'h25, 3'd1);
        cfg_wr(12'hA1C, 32'h01, 3'd1);
        rd_chk("R10 delegated keeps", 12'hA1C, 32'h25);
        cfg_wr(12'hA1C, 32'h01, 3'd2);
        rd_chk("R10 delegate write", 12'hA1C, 32'h01);
        cfg_wr(12'h00C, 32'h1, 3'd0);
        rd_chk("R9 cfg clear", 12'h008, {30'b0, m_ill, m_cfg});

        // R9 violation in the same cycle as a clear
        check("R9 pre flag", {31'b0, viol_alert}, 32'h1);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 1; cfg_addr = 12'h00C; cfg_wdata = 32'h2; cfg_cid = 0;
        acc_valid = 1; acc_addr = 17'h03400; acc_cid = 3'd4; acc_sec = 0; acc_priv = 0; acc_write = 0;
        model_cfg(12'h00C, 32'h2, 3'd0);
        note_access(17'h03400, 3'd4, 0, 0, 0, 1'b0, 1'b1);
        @(negedge clk);
        cfg_valid = 0; cfg_write = 0; acc_valid = 0;
        rd_chk("R9 set wins", 12'h008, 32'h2);
        rd_chk("R9 recapture", 12'h024, 32'h0000_3400);
        rd_chk("R9 synd", 12'h020, 32'h04);

        // random phase
        cfg_wr(12'h00C, 32'h3, 3'd0);
        for (int i = 0; i < 500; i++) begin
            int k;
            k = int'($urandom % 10);
            if (k < 2) begin
                int kind;
                bit [4:0] pg;
                bit [2:0] c;
                kind = int'($urandom % 5);
                pg = 5'($urandom);
                c = 3'($urandom % 7);
                case (kind)
                    0: cfg_wr(12'h000, $urandom, 3'd0);
                    1: cfg_wr({4'h1, 1'b0, pg, 2'b00}, $urandom & $urandom & 32'hFF, 3'd0);
                    2: cfg_wr({4'h2, 1'b0, pg, 2'b00}, $urandom & $urandom & 32'hFF, 3'd0);
                    3: cfg_wr({4'h8, c, 5'(8 * ($urandom % 3))}, $urandom, 3'd0);
                    default: cfg_wr({4'hA, 1'b0, pg, 2'b00}, $urandom & 32'h75, 3'($urandom));
                endcase
            end else begin
                access(17'($urandom), 3'($urandom % 8), 1'($urandom), 1'($urandom),
                       1'($urandom), "R6 random grant");
            end
        end
        rd_chk("R8 final status", 12'h008, {30'b0, m_ill, m_cfg});
        rd_chk("R8 final addr", 12'h024, m_va);
        rd_chk("R8 final synd", 12'h020, {25'b0, m_sy});

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule